// File: doc/BRIEF.md
# Wake-up event latch and interrupt aggregator

This block collects wake-up requests from many peripherals inside a power and reset controller. Requests arrive on an already synchronized input vector that is split into several equal banks. Each bank keeps a sticky status register and a wake-enable mask. Only enabled sources can latch. Two selection masks per bank pick which latched bits count toward the main processor and which count toward an auxiliary processor.

Any latched bit that the main processor has selected raises an aggregate wake flag, bit 0 of an interrupt status register. A separate I/O wake input raises bit 1 of the same register. An interrupt-enable register masks both flags, and the block drives one interrupt line to the main processor. Software clears the status registers by writing ones through a simple synchronous register port. The aggregate wake flag resists that clear for as long as any selected bank bit is still latched. An event that lands in the same cycle as a clear is never lost.

Top module: `wake_aggr`

## Requirements
- R1: After reset every register reads 0, and `irq_main` and `aux_wake` are low.
- R2: A bank status bit sets on the clock edge after its `wake_in` bit is high, and only if its wake-enable bit is 1. A source that is not enabled never sets its status bit.
- R3: A write to a bank status register (kind 0) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When a source event and a clear of that status bit happen in the same cycle, the bit stays set.
- R5: Interrupt status bit 0 (wake flag) is set on the edge after any bank holds a bit that is both latched and selected for the main processor. Latched bits that are not selected never set it.
- R6: Writing 1 to interrupt status bit 0 clears it only when no bank holds a latched, main-selected bit. Otherwise it stays 1.
- R7: Interrupt status bit 1 (I/O wake flag) is set on the edge after `io_wake` is high. It is cleared by writing 1 to it, and a coincident `io_wake` wins over the clear.
- R8: `irq_main` is high exactly when some interrupt status bit and the matching interrupt-enable bit (kind 5, bit 0 wake, bit 1 I/O) are both 1.
- R9: `aux_wake` is high exactly when some bank holds a latched bit that is also set in that bank's auxiliary selection mask (kind 3).
- R10: Register address = {kind[2:0], bank}. The kinds are 0 status, 1 wake-enable, 2 main select, 3 auxiliary select, 4 interrupt status (bank field 0), and 5 interrupt enable (bank field 0). A read returns the value on `reg_rdata` one cycle after `reg_rd`. Unmapped addresses read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_in | input | NBANK*BW | Synchronized wake requests; bank b occupies bits b*BW upward |
| io_wake | input | 1 | Synchronized I/O wake request |
| reg_addr | input | 3+log2(NBANK) | Register address {kind, bank} |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | BW | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | BW | Registered read data |
| irq_main | output | 1 | Interrupt to the main processor |
| aux_wake | output | 1 | Wake request toward the auxiliary processor |

## Verification
A wake pulse on the input shows in the bank status after one edge. It reaches the interrupt status flags one edge later, and `irq_main` follows that register without any further delay. `aux_wake` follows the bank status directly. A register read returns its data after the edge that samples `reg_rd`. The bench drives every stimulus on the falling edge and lets the needed number of rising edges pass before it looks. It then samples the result on the next falling edge, so each check sees the register state left by exactly the edges counted above.

// File: rtl/wake_aggr_pkg.sv
package wake_aggr_pkg;

  typedef enum logic [2:0] {
    K_STATUS  = 3'd0,
    K_ENABLE  = 3'd1,
    K_SEL_MAIN = 3'd2,
    K_SEL_AUX = 3'd3,
    K_IRQ_ST  = 3'd4,
    K_IRQ_EN  = 3'd5
  } reg_kind_e;

  // Sticky bit with write-one-to-clear; a set in the same cycle wins.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Flag whose clear is refused while a holding condition is true.
  function automatic logic guarded_next(input logic cur, input logic hold, input logic clr);
    return hold | (cur & ~clr);
  endfunction

endpackage

// File: rtl/wake_bank.sv
module wake_bank #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] wake,
  input  logic          wr_stat,
  input  logic          wr_en,
  input  logic          wr_main,
  input  logic          wr_aux,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] stat,
  output logic [BW-1:0] en,
  output logic [BW-1:0] sel_main,
  output logic [BW-1:0] sel_aux,
  output logic [BW-1:0] clr_mask,
  output logic          qual_main,
  output logic          qual_aux
);
  import wake_aggr_pkg::*;

  logic [BW-1:0] stat_d;

  assign clr_mask = wr_stat ? wdata : '0;

  for (genvar i = 0; i < BW; i++) begin : g_bit
    assign stat_d[i] = sticky_next(stat[i], wake[i] & en[i], clr_mask[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat     <= '0;
      en       <= '0;
      sel_main <= '0;
      sel_aux  <= '0;
    end else begin
      stat <= stat_d;
      if (wr_en)   en       <= wdata;
      if (wr_main) sel_main <= wdata;
      if (wr_aux)  sel_aux  <= wdata;
    end
  end

  assign qual_main = |(stat & sel_main);
  assign qual_aux  = |(stat & sel_aux);
endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       qual_any,
  input  logic       io_wake,
  input  logic       wr_st,
  input  logic       wr_en,
  input  logic [1:0] wdata,
  output logic [1:0] irq_st,
  output logic [1:0] irq_en,
  output logic       irq_out
);
  import wake_aggr_pkg::*;

  logic [1:0] st_d;
  logic [1:0] clr;

  assign clr     = wr_st ? wdata : 2'b00;
  assign st_d[0] = guarded_next(irq_st[0], qual_any, clr[0]);
  assign st_d[1] = sticky_next(irq_st[1], io_wake, clr[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_st <= 2'b00;
      irq_en <= 2'b00;
    end else begin
      irq_st <= st_d;
      if (wr_en) irq_en <= wdata;
    end
  end

  assign irq_out = |(irq_st & irq_en);
endmodule

// File: rtl/wake_rd_port.sv
module wake_rd_port #(
  parameter int NBANK = 4,
  parameter int BW    = 8,
  localparam int BANK_BITS = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd,
  input  logic [2:0]            kind,
  input  logic [BANK_BITS-1:0]  bank,
  input  logic [NBANK*BW-1:0]   stat_all,
  input  logic [NBANK*BW-1:0]   en_all,
  input  logic [NBANK*BW-1:0]   main_all,
  input  logic [NBANK*BW-1:0]   aux_all,
  input  logic [1:0]            irq_st,
  input  logic [1:0]            irq_en,
  output logic [BW-1:0]         rdata
);
  import wake_aggr_pkg::*;

  logic [BW-1:0] val;
  logic          bank_ok;

  assign bank_ok = (int'(bank) < NBANK);

  always_comb begin
    val = '0;
    unique case (reg_kind_e'(kind))
      K_STATUS:   if (bank_ok) val = stat_all[int'(bank)*BW +: BW];
      K_ENABLE:   if (bank_ok) val = en_all[int'(bank)*BW +: BW];
      K_SEL_MAIN: if (bank_ok) val = main_all[int'(bank)*BW +: BW];
      K_SEL_AUX:  if (bank_ok) val = aux_all[int'(bank)*BW +: BW];
      K_IRQ_ST:   if (bank == '0) val[1:0] = irq_st;
      K_IRQ_EN:   if (bank == '0) val[1:0] = irq_en;
      default:    val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd) rdata <= val;
  end
endmodule

// File: rtl/wake_aggr.sv
module wake_aggr #(
  parameter int NBANK = 4,
  parameter int BW    = 8,
  localparam int BANK_BITS = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int ADDR_W    = 3 + BANK_BITS,
  localparam int WAKE_W    = NBANK * BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAKE_W-1:0] wake_in,
  input  logic              io_wake,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [BW-1:0]     reg_wdata,
  input  logic              reg_rd,
  output logic [BW-1:0]     reg_rdata,
  output logic              irq_main,
  output logic              aux_wake
);
  import wake_aggr_pkg::*;

  logic [2:0]           kind;
  logic [BANK_BITS-1:0] bank;
  logic [WAKE_W-1:0]    stat_all, en_all, main_all, aux_all, clr_all;
  logic [NBANK-1:0]     qual_main_v, qual_aux_v;
  logic                 qual_any;
  logic [1:0]           irq_st, irq_en;
  logic                 wr_irq_st, wr_irq_en;

  assign kind = reg_addr[ADDR_W-1 -: 3];
  assign bank = reg_addr[BANK_BITS-1:0];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = reg_wr && (int'(bank) == b);
    wake_bank #(.BW(BW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wake      (wake_in[b*BW +: BW]),
      .wr_stat   (hit && kind == K_STATUS),
      .wr_en     (hit && kind == K_ENABLE),
      .wr_main   (hit && kind == K_SEL_MAIN),
      .wr_aux    (hit && kind == K_SEL_AUX),
      .wdata     (reg_wdata),
      .stat      (stat_all[b*BW +: BW]),
      .en        (en_all[b*BW +: BW]),
      .sel_main  (main_all[b*BW +: BW]),
      .sel_aux   (aux_all[b*BW +: BW]),
      .clr_mask  (clr_all[b*BW +: BW]),
      .qual_main (qual_main_v[b]),
      .qual_aux  (qual_aux_v[b])
    );
  end

  assign qual_any  = |qual_main_v;
  assign aux_wake  = |qual_aux_v;
  assign wr_irq_st = reg_wr && kind == K_IRQ_ST && bank == '0;
  assign wr_irq_en = reg_wr && kind == K_IRQ_EN && bank == '0;

  wake_irq_ctrl u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .qual_any (qual_any),
    .io_wake  (io_wake),
    .wr_st    (wr_irq_st),
    .wr_en    (wr_irq_en),
    .wdata    (reg_wdata[1:0]),
    .irq_st   (irq_st),
    .irq_en   (irq_en),
    .irq_out  (irq_main)
  );

  wake_rd_port #(.NBANK(NBANK), .BW(BW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (reg_rd),
    .kind     (kind),
    .bank     (bank),
    .stat_all (stat_all),
    .en_all   (en_all),
    .main_all (main_all),
    .aux_all  (aux_all),
    .irq_st   (irq_st),
    .irq_en   (irq_en),
    .rdata    (reg_rdata)
  );
endmodule

// File: rtl/wake_aggr_chk.sv
module wake_aggr_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] wake_in,
  input logic [W-1:0] en_all,
  input logic [W-1:0] stat_all,
  input logic [W-1:0] clr_all,
  input logic         qual_any,
  input logic [1:0]   irq_st,
  input logic [1:0]   irq_en,
  input logic         irq_main
);
  p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_all & $past(wake_in & en_all)) == $past(wake_in & en_all)));

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_all & ~$past(stat_all) & ~$past(wake_in & en_all)) == '0));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_all & wake_in & en_all)) |=>
      ((stat_all & $past(clr_all & wake_in & en_all)) == $past(clr_all & wake_in & en_all)));

  p_wake_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    qual_any |=> irq_st[0]);

  p_clr_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_any && irq_st[0]) |=> irq_st[0]);

  p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 2'b00) |-> !irq_main);
endmodule

bind wake_aggr wake_aggr_chk #(.W(WAKE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wake_in  (wake_in),
  .en_all   (en_all),
  .stat_all (stat_all),
  .clr_all  (clr_all),
  .qual_any (qual_any),
  .irq_st   (irq_st),
  .irq_en   (irq_en),
  .irq_main (irq_main)
);

// File: tb/sim_wake_aggr.sv
`timescale 1ns/1ps
module sim_wake_aggr;
  localparam int NB = 4;
  localparam int BW = 8;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB*BW-1:0] wake_in = '0;
  logic          io_wake = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [BW-1:0] reg_wdata = '0;
  logic          reg_rd = 1'b0;
  logic [BW-1:0] reg_rdata;
  logic          irq_main, aux_wake;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wake_aggr #(.NBANK(NB), .BW(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .io_wake(io_wake),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_main(irq_main), .aux_wake(aux_wake)
  );

  function automatic logic [AW-1:0] ad(input int kind, input int bank);
    return AW'(kind * NB + bank);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [BW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [BW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [NB*BW-1:0] v);
    @(negedge clk);
    wake_in = v;
    @(negedge clk);
    wake_in = '0;
  endtask

  initial begin
    logic [BW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10: every address reads zero after reset
    chk("R1 irq_main", irq_main, 0);
    chk("R1 aux_wake", aux_wake, 0);
    for (int a = 0; a < 32; a++) begin
      rd(AW'(a), d);
      chk("R1 reset read", d, 0);
    end

    // R10: register readback and unmapped addresses
    for (int b = 0; b < NB; b++) begin
      wr(ad(1, b), BW'(8'hA5 ^ b));
      wr(ad(3, b), BW'(8'h3C + b));
    end
    for (int b = 0; b < NB; b++) begin
      rd(ad(1, b), d); chk("R10 enable readback", d, 8'hA5 ^ b);
      rd(ad(3, b), d); chk("R10 aux select readback", d, 8'h3C + b);
    end
    wr(ad(3, 0), 0); wr(ad(3, 1), 0); wr(ad(3, 2), 0); wr(ad(3, 3), 0);
    wr(ad(4, 1), 8'hFF); rd(ad(4, 1), d); chk("R10 unmapped irq bank1", d, 0);
    wr(ad(6, 0), 8'hFF); rd(ad(6, 0), d); chk("R10 unmapped kind6", d, 0);
    wr(ad(7, 3), 8'hFF); rd(ad(7, 3), d); chk("R10 unmapped kind7", d, 0);

    // R2 / R3: sweep each source bit; latch only when enabled, then W1C
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < BW; i++) begin
        logic [BW-1:0] en_pat;
        en_pat = BW'(8'hA5 ^ b);
        pulse((NB*BW)'(1) << (b*BW + i));
        rd(ad(0, b), d);
        chk("R2 latch gated by enable", d, int'(en_pat & (BW'(1) << i)));
        wr(ad(0, b), 8'hFF);
        rd(ad(0, b), d);
        chk("R3 clear all", d, 0);
      end
    end

    // R3: partial W1C
    for (int b = 0; b < NB; b++) wr(ad(1, b), 8'hFF);
    pulse('1);
    wr(ad(0, 1), 8'h0F);
    rd(ad(0, 1), d); chk("R3 partial clear", d, 8'hF0);
    wr(ad(0, 1), 8'h00);
    rd(ad(0, 1), d); chk("R3 zero write keeps", d, 8'hF0);

    // R4: event coincides with clear
    @(negedge clk);
    reg_addr = ad(0, 2); reg_wdata = 8'hFF; reg_wr = 1'b1;
    wake_in = (NB*BW)'(8'h12) << (2*BW);
    @(negedge clk);
    reg_wr = 1'b0; wake_in = '0;
    rd(ad(0, 2), d); chk("R4 set wins over clear", d, 8'h12);
    for (int b = 0; b < NB; b++) wr(ad(0, b), 8'hFF);

    // R5: unselected bits do not raise wake flag
    wr(ad(2, 2), 8'h01);
    pulse((NB*BW)'(8'h02) << (2*BW));
    @(negedge clk);
    rd(ad(4, 0), d); chk("R5 unselected no wake", d & 1, 0);
    pulse((NB*BW)'(8'h01) << (2*BW));
    @(negedge clk);
    rd(ad(4, 0), d); chk("R5 selected sets wake", d & 1, 1);

    // R8: interrupt gating
    chk("R8 masked", irq_main, 0);
    wr(ad(5, 0), 8'h02);
    chk("R8 wrong enable", irq_main, 0);
    wr(ad(5, 0), 8'h01);
    chk("R8 enabled wake", irq_main, 1);

    // R6: clear refused while selected bit latched
    wr(ad(4, 0), 8'h01);
    rd(ad(4, 0), d); chk("R6 clear blocked", d & 1, 1);
    wr(ad(0, 2), 8'hFF);
    wr(ad(4, 0), 8'h01);
    rd(ad(4, 0), d); chk("R6 clear after banks empty", d & 1, 0);
    chk("R8 deasserted", irq_main, 0);

    // R4/R6: clear race keeps both bank bit and wake flag
    pulse((NB*BW)'(8'h01) << (2*BW));
    @(negedge clk);
    reg_addr = ad(0, 2); reg_wdata = 8'h01; reg_wr = 1'b1;
    wake_in = (NB*BW)'(8'h01) << (2*BW);
    @(negedge clk);
    reg_wr = 1'b0; wake_in = '0;
    wr(ad(4, 0), 8'h01);
    rd(ad(4, 0), d); chk("R6 race keeps wake", d & 1, 1);
    rd(ad(0, 2), d); chk("R4 race keeps bank bit", d, 8'h01);
    wr(ad(0, 2), 8'hFF);
    wr(ad(4, 0), 8'h01);

    // R7: I/O wake flag
    @(negedge clk); io_wake = 1'b1;
    @(negedge clk); io_wake = 1'b0;
    rd(ad(4, 0), d); chk("R7 io flag set", d, 8'h02);
    wr(ad(5, 0), 8'h02);
    chk("R8 io irq", irq_main, 1);
    @(negedge clk);
    reg_addr = ad(4, 0); reg_wdata = 8'h02; reg_wr = 1'b1; io_wake = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; io_wake = 1'b0;
    rd(ad(4, 0), d); chk("R7 io set wins", d, 8'h02);
    wr(ad(4, 0), 8'h02);
    rd(ad(4, 0), d); chk("R7 io cleared", d, 0);

    // R9: auxiliary wake
    wr(ad(3, 3), 8'h80);
    pulse((NB*BW)'(8'h40) << (3*BW));
    chk("R9 unselected aux", aux_wake, 0);
    pulse((NB*BW)'(8'h80) << (3*BW));
    chk("R9 aux set", aux_wake, 1);
    wr(ad(0, 3), 8'h80);
    chk("R9 aux cleared", aux_wake, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule